// File: doc/BRIEF.md
# Store Address Conflict Table

This block keeps the effective addresses of stores that have computed their address but not yet committed. Each occupied slot holds a 32-bit address together with the reorder-buffer tag of its store. Every cycle a load presents its address, and the block answers at once whether some pending store uses exactly that address. The load may go ahead only when no such store exists. Loads are ordered against stores only by this exact address match, never by age.

A store writes its address into a free slot when the address is ready. It leaves the table, found by its tag, in the cycle it commits. A full table refuses further inserts and says so on a flag, so the producer holds the store back. When a branch resolves wrongly, a flush removes every store younger than a given reorder-buffer index, with age measured from the current buffer head.

Top module: `store_conflict_table`

## Requirements
- R1: After reset the table is empty: `ld_block` is 0 for every load address and `full` is 0.
- R2: `ld_block` is 1 exactly when some occupied slot holds an address equal to `ld_addr` in all 32 bits. An address that differs in any single bit does not block.
- R3: An insert (`ins_valid`=1) while `full`=0 takes a free slot from the next cycle on. `full` is 1 exactly when all DEPTH slots are occupied.
- R4: An insert while `full`=1 is ignored: its address never blocks a load, either in that cycle or later.
- R5: A retire (`ret_valid`=1) frees the slot whose tag equals `ret_tag`, effective the next cycle. A retire tag that matches no slot changes nothing.
- R6: A load sees an insert accepted in the same cycle: `ld_block` is 1 in that cycle when `ld_addr` equals `ins_addr`.
- R7: A flush (`flush_valid`=1) frees every slot whose tag is younger than `flush_tag`. Younger means (tag - `rob_head`) mod 2^TAG_W is greater than (`flush_tag` - `rob_head`) mod 2^TAG_W. The slot holding `flush_tag` itself and older slots are kept.
- R8: An insert during a flush whose tag is younger than `flush_tag` (under the R7 rule) is dropped, and it is not seen by a load in that cycle. An insert that is not younger is taken normally.
- R9: A retire and an insert in the same cycle both take effect. Whether the insert is accepted depends on `full` before the retire.
- R10: A flush and a retire in the same cycle both take effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ins_valid | input | 1 | Store address insert request |
| ins_addr | input | ADDR_W | Store effective address |
| ins_tag | input | TAG_W | Reorder-buffer tag of the store |
| full | output | 1 | All slots occupied; inserts are refused |
| ret_valid | input | 1 | Store commit |
| ret_tag | input | TAG_W | Tag of the committing store |
| flush_valid | input | 1 | Remove stores younger than `flush_tag` |
| flush_tag | input | TAG_W | Youngest reorder-buffer index that survives the flush |
| rob_head | input | TAG_W | Current reorder-buffer head, the reference point for age |
| ld_addr | input | ADDR_W | Load effective address |
| ld_block | output | 1 | A pending store has the same address; the load must wait |

## Verification
Two kinds of events can land in the same cycle. The first is an insert together with a load lookup or a retire. The second is a flush together with an insert or a retire. The bench drives these pairs on purpose: retire+insert on a full table, a flush paired with inserts of both young and old tags, and a flush paired with a retire. Random traffic also produces them often, because a small address pool makes load hits and duplicate addresses common. Each cycle, a bench model of the set of pending stores predicts `ld_block`, including the forwarded insert, and `full`. The next cycle's probes show which of the same-cycle actions actually took effect.

// File: rtl/sct_pkg.sv
package sct_pkg;
  localparam int unsigned MAX_TAG_W = 16;

  // True when tag t is younger than boundary b, ages taken from head h modulo 2^w.
  function automatic logic is_younger(input logic [MAX_TAG_W-1:0] t,
                                      input logic [MAX_TAG_W-1:0] h,
                                      input logic [MAX_TAG_W-1:0] b,
                                      input int w);
    logic [MAX_TAG_W-1:0] m;
    logic [MAX_TAG_W-1:0] age_t;
    logic [MAX_TAG_W-1:0] age_b;
    m     = MAX_TAG_W'((32'd1 << w) - 32'd1);
    age_t = (t - h) & m;
    age_b = (b - h) & m;
    return age_t > age_b;
  endfunction
endpackage

// File: rtl/sct_rst_sync.sv
module sct_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_sync = sync_q[1];
endmodule

// File: rtl/sct_cam_match.sv
module sct_cam_match #(
  parameter int N = 8,
  parameter int W = 32
) (
  input  logic [W-1:0]        key,
  input  logic [N-1:0][W-1:0] data,
  output logic [N-1:0]        eq
);
  for (genvar i = 0; i < N; i++) begin : g_cmp
    assign eq[i] = (data[i] == key);
  end
endmodule

// File: rtl/sct_free_pick.sv
module sct_free_pick #(
  parameter int N = 8
) (
  input  logic [N-1:0] busy,
  output logic [N-1:0] grant
);
  always_comb begin
    logic found;
    found = 1'b0;
    grant = '0;
    for (int i = 0; i < N; i++) begin
      if (!busy[i] && !found) begin
        grant[i] = 1'b1;
        found    = 1'b1;
      end
    end
  end
endmodule

// File: rtl/store_conflict_table.sv
module store_conflict_table #(
  parameter int DEPTH  = 8,
  parameter int ADDR_W = 32,
  parameter int TAG_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ins_valid,
  input  logic [ADDR_W-1:0] ins_addr,
  input  logic [TAG_W-1:0]  ins_tag,
  output logic              full,
  input  logic              ret_valid,
  input  logic [TAG_W-1:0]  ret_tag,
  input  logic              flush_valid,
  input  logic [TAG_W-1:0]  flush_tag,
  input  logic [TAG_W-1:0]  rob_head,
  input  logic [ADDR_W-1:0] ld_addr,
  output logic              ld_block
);
  localparam int PW = sct_pkg::MAX_TAG_W;

  logic                         rst_s;
  logic [DEPTH-1:0]             valid_q, valid_d;
  logic [DEPTH-1:0][ADDR_W-1:0] addr_q;
  logic [DEPTH-1:0][TAG_W-1:0]  tag_q;
  logic [DEPTH-1:0]             grant, wr_en;
  logic [DEPTH-1:0]             addr_eq, tag_eq;
  logic [DEPTH-1:0]             ld_hit, ret_hit, kill;
  logic                         ins_young, ins_acc;

  sct_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_n_sync(rst_s));

  sct_free_pick #(.N(DEPTH)) u_pick (.busy(valid_q), .grant(grant));

  sct_cam_match #(.N(DEPTH), .W(ADDR_W)) u_ld_cam (
    .key(ld_addr), .data(addr_q), .eq(addr_eq));

  sct_cam_match #(.N(DEPTH), .W(TAG_W)) u_ret_cam (
    .key(ret_tag), .data(tag_q), .eq(tag_eq));

  for (genvar i = 0; i < DEPTH; i++) begin : g_kill
    assign kill[i] = flush_valid && valid_q[i] &&
                     sct_pkg::is_younger(PW'(tag_q[i]), PW'(rob_head), PW'(flush_tag), TAG_W);
  end

  // Next state
  always_comb begin
    full      = &valid_q;
    ins_young = flush_valid &&
                sct_pkg::is_younger(PW'(ins_tag), PW'(rob_head), PW'(flush_tag), TAG_W);
    ins_acc   = ins_valid && !full && !ins_young;
    ld_hit    = addr_eq & valid_q;
    ret_hit   = tag_eq & valid_q & {DEPTH{ret_valid}};
    ld_block  = (|ld_hit) || (ins_acc && (ins_addr == ld_addr));
    wr_en     = grant & {DEPTH{ins_acc}};
    valid_d   = (valid_q & ~ret_hit & ~kill) | wr_en;
  end

  // Registers
  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) valid_q <= '0;
    else        valid_q <= valid_d;
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    always_ff @(posedge clk or negedge rst_s) begin
      if (!rst_s) begin
        addr_q[i] <= '0;
        tag_q[i]  <= '0;
      end else if (wr_en[i]) begin
        addr_q[i] <= ins_addr;
        tag_q[i]  <= ins_tag;
      end
    end

    // R7: no survivor of a flush is younger than the boundary
    p_flush_kill_r7: assert property (@(posedge clk) disable iff (!rst_s)
      flush_valid |=> !(valid_q[i] &&
        sct_pkg::is_younger(PW'(tag_q[i]), PW'($past(rob_head)), PW'($past(flush_tag)), TAG_W)));
  end

  p_grant_onehot_r3: assert property (@(posedge clk) disable iff (!rst_s)
    $onehot0(wr_en));

  p_full_hold_r4: assert property (@(posedge clk) disable iff (!rst_s)
    full && !ret_valid && !flush_valid |=> full && $stable(addr_q));

  p_insert_grows_r3: assert property (@(posedge clk) disable iff (!rst_s)
    ins_acc && !ret_valid && !flush_valid |=>
      $countones(valid_q) == $countones($past(valid_q)) + 1);

  p_retire_shrinks_r5: assert property (@(posedge clk) disable iff (!rst_s)
    (|ret_hit) && !ins_valid && !flush_valid |=>
      $countones(valid_q) + 1 == $countones($past(valid_q)));

  p_empty_clear_r2: assert property (@(posedge clk) disable iff (!rst_s)
    (valid_q == '0) && !ins_valid |-> !ld_block);
endmodule

// File: tb/store_conflict_table_tb_top.sv
module store_conflict_table_tb_top;
  localparam int DEPTH = 8;
  localparam int AW    = 32;
  localparam int TW    = 4;

  logic          clk;
  logic          rst_n;
  logic          ins_valid, ret_valid, flush_valid;
  logic [AW-1:0] ins_addr, ld_addr;
  logic [TW-1:0] ins_tag, ret_tag, flush_tag, rob_head;
  logic          full, ld_block;

  int errors = 0;
  int checks = 0;

  // model: the set of pending stores
  logic [AW-1:0] m_addr [DEPTH];
  logic [TW-1:0] m_tag  [DEPTH];
  int            m_n = 0;

  store_conflict_table #(.DEPTH(DEPTH), .ADDR_W(AW), .TAG_W(TW)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .ins_valid(ins_valid), .ins_addr(ins_addr), .ins_tag(ins_tag), .full(full),
    .ret_valid(ret_valid), .ret_tag(ret_tag),
    .flush_valid(flush_valid), .flush_tag(flush_tag), .rob_head(rob_head),
    .ld_addr(ld_addr), .ld_block(ld_block));

  initial clk = 1'b0;
  always #10 clk = ~clk;

  function automatic bit younger(logic [TW-1:0] t, logic [TW-1:0] h, logic [TW-1:0] b);
    logic [TW-1:0] at, ab;
    at = t - h;
    ab = b - h;
    return at > ab;
  endfunction

  function automatic bit ins_taken();
    return ins_valid && (m_n < DEPTH) &&
           !(flush_valid && younger(ins_tag, rob_head, flush_tag));
  endfunction

  function automatic bit exp_block();
    for (int i = 0; i < m_n; i++) if (m_addr[i] == ld_addr) return 1'b1;
    return ins_taken() && (ins_addr == ld_addr);
  endfunction

  function automatic bit tag_pending(logic [TW-1:0] t);
    for (int i = 0; i < m_n; i++) if (m_tag[i] == t) return 1'b1;
    return 1'b0;
  endfunction

  task automatic check(string req, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0b expected=%0b", req, act, exp);
    end
  endtask

  task automatic update_model();
    bit take;
    int k;
    take = ins_taken();
    k = 0;
    for (int i = 0; i < m_n; i++) begin
      if (!(ret_valid && m_tag[i] == ret_tag) &&
          !(flush_valid && younger(m_tag[i], rob_head, flush_tag))) begin
        m_addr[k] = m_addr[i];
        m_tag[k]  = m_tag[i];
        k++;
      end
    end
    if (take) begin
      m_addr[k] = ins_addr;
      m_tag[k]  = ins_tag;
      k++;
    end
    m_n = k;
  endtask

  task automatic step(string req, bit iv, logic [AW-1:0] ia, logic [TW-1:0] it,
                      bit rv, logic [TW-1:0] rt, bit fv, logic [TW-1:0] ft,
                      logic [TW-1:0] hd, logic [AW-1:0] la);
    @(negedge clk);
    ins_valid = iv; ins_addr = ia; ins_tag = it;
    ret_valid = rv; ret_tag = rt;
    flush_valid = fv; flush_tag = ft; rob_head = hd;
    ld_addr = la;
    #5;
    check(req, ld_block, exp_block());
    check(req, full, (m_n == DEPTH));
    @(posedge clk);
    update_model();
  endtask

  task automatic probe(string req, logic [AW-1:0] la);
    step(req, 0, '0, '0, 0, '0, 0, '0, '0, la);
  endtask

  initial begin
    #(20 * 200000);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int unsigned seed;
    seed = 32'h5C7A_0011;
    void'($urandom(seed));
    ins_valid = 0; ret_valid = 0; flush_valid = 0;
    ins_addr = '0; ins_tag = '0; ret_tag = '0; flush_tag = '0; rob_head = '0; ld_addr = '0;
    rst_n = 0;
    repeat (3) @(posedge clk);
    #5;
    check("R1", ld_block, 1'b0);
    check("R1", full, 1'b0);
    @(negedge clk);
    rst_n = 1;
    repeat (3) @(posedge clk);
    probe("R1", 32'h0);

    // R6 same-cycle visibility, R2 exact match
    step("R6", 1, 32'h1000_0040, 4'd1, 0, '0, 0, '0, '0, 32'h1000_0040);
    probe("R2", 32'h1000_0040);
    probe("R2", 32'h1000_0041);
    probe("R2", 32'h9000_0040);
    // R5 retire, and a retire tag with no match
    step("R5", 1, 32'h2000_0000, 4'd2, 1, 4'd1, 0, '0, '0, 32'h1000_0040);
    probe("R5", 32'h1000_0040);
    step("R5", 0, '0, '0, 1, 4'd9, 0, '0, '0, 32'h2000_0000);
    probe("R5", 32'h2000_0000);
    // R3 fill to full
    for (int i = 3; i < 10; i++)
      step("R3", 1, 32'h3000_0000 + i, 4'(i), 0, '0, 0, '0, '0, 32'h3000_0000 + i);
    probe("R3", 32'h3000_0009);
    // R4 insert while full
    step("R4", 1, 32'hDEAD_0000, 4'd12, 0, '0, 0, '0, '0, 32'hDEAD_0000);
    probe("R4", 32'hDEAD_0000);
    // R9 retire plus insert on a full table: insert refused, retire done
    step("R9", 1, 32'hBEEF_0000, 4'd13, 1, 4'd3, 0, '0, '0, 32'hBEEF_0000);
    probe("R9", 32'hBEEF_0000);
    probe("R9", 32'h3000_0003);
    // R9 retire plus insert when not full: both apply
    step("R9", 1, 32'hBEEF_0004, 4'd14, 1, 4'd4, 0, '0, '0, 32'h3000_0004);
    probe("R9", 32'hBEEF_0004);
    probe("R9", 32'h3000_0004);
    // R7 flush with head 2, boundary 6: tags 7,8,9,14 go; 2,5,6 stay
    step("R7", 0, '0, '0, 0, '0, 1, 4'd6, 4'd2, 32'h3000_0007);
    probe("R7", 32'h3000_0007);
    probe("R7", 32'h3000_0009);
    probe("R7", 32'hBEEF_0004);
    probe("R7", 32'h3000_0006);
    probe("R7", 32'h3000_0005);
    // R8 inserts during a flush: young dropped, old kept
    step("R8", 1, 32'h4000_0000, 4'd10, 0, '0, 1, 4'd6, 4'd2, 32'h4000_0000);
    probe("R8", 32'h4000_0000);
    step("R8", 1, 32'h4000_0001, 4'd3, 0, '0, 1, 4'd5, 4'd2, 32'h4000_0001);
    probe("R8", 32'h4000_0001);
    probe("R8", 32'h3000_0006);
    // R10 flush and retire together: retire tag 2, flush everything past tag 3
    step("R10", 0, '0, '0, 1, 4'd2, 1, 4'd3, 4'd2, 32'h2000_0000);
    probe("R10", 32'h2000_0000);
    probe("R10", 32'h3000_0005);
    probe("R10", 32'h4000_0001);

    // Random traffic; checks of ld_block follow R2, of full follow R3
    for (int n = 0; n < 4000; n++) begin
      bit iv, rv, fv;
      logic [TW-1:0] it, rt, ft, hd;
      logic [AW-1:0] ia, la;
      iv = ($urandom % 3) != 0;
      it = 4'($urandom);
      for (int g = 0; g < 16 && tag_pending(it); g++) it = it + 4'd1;
      if (tag_pending(it)) iv = 0;
      ia = 32'h5000_0000 + ($urandom % 12);
      la = 32'h5000_0000 + ($urandom % 14);
      rv = ($urandom % 3) == 0;
      rt = (m_n > 0 && ($urandom % 4) != 0) ? m_tag[$urandom % m_n] : 4'($urandom);
      fv = ($urandom % 23) == 0;
      ft = 4'($urandom);
      hd = 4'($urandom);
      step("R2/R3 random", iv, ia, it, rv, rt, fv, ft, hd, la);
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule